// File: doc/BRIEF.md
# Selectable-Trigger Interrupt Request Register

This block keeps the pending-request state for a group of interrupt lines, eight by default. Each line is either edge triggered or level triggered, as selected by one bit of a trigger-mode register. A level-mode line shows pending for exactly as long as its input is high. An edge-mode line latches a request when its input rises and holds it until the line is acknowledged.

The raw request lines are sampled once per clock. The block records the level it last saw on each line so that a rise can be detected. An acknowledge strobe with a line index withdraws an edge-mode request. A level-mode request is left pending, because it must stay asserted for as long as its source holds it.

Writes to the trigger-mode register pass through a per-instance writable mask. Any line whose mask bit is zero stays in edge mode permanently. For example, the default mask 0xF8 pins lines 0 to 2 to edge mode, and a second instance might use 0xDE. Priority selection, masking of requests and command decoding belong to neighbouring blocks.

Top module: `trig_irq_pending`

## Requirements
- R1: For a line whose trigger-mode bit is 1 (level mode), the pending bit after a clock edge equals the input level sampled at that edge. An acknowledge of that line has no effect on it.
- R2: For a line whose trigger-mode bit is 0 (edge mode), the pending bit is set at a clock edge where the sampled input is 1 and the recorded level of that line is 0.
- R3: An edge-mode pending bit that is not acknowledged stays set when its input falls. An edge-mode input held high after its acknowledge produces no further pending event.
- R4: The recorded level of every line takes the sampled input value at every clock edge, in either mode. A line switched from level to edge mode while its input is high therefore produces no new pending event.
- R5: With the acknowledge strobe high, the line given by the 3-bit acknowledge index loses its pending bit at the next edge only if it is in edge mode. All other lines are unaffected.
- R6: When an acknowledge and a new rising edge hit the same edge-mode line in the same cycle, the pending bit ends up set.
- R7: A write to the trigger-mode register stores the written byte ANDed with the parameter MODE_WMASK (default 0xF8). The readback port shows the stored value from the next cycle. The new modes govern sampling from the cycle after the write.
- R8: With the synchronous reset high at a clock edge, the pending vector, the recorded levels and the trigger-mode register all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Raw interrupt request lines |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Index of the acknowledged line |
| mode_wr_en | input | 1 | Trigger-mode register write enable |
| mode_wr_data | input | 8 | Trigger-mode write value, 1 = level mode |
| pend_q | output | 8 | Pending-request vector |
| mode_q | output | 8 | Trigger-mode register readback |

## Verification
The hardest case to reach is a line whose recorded level differs from what a plain edge detector would expect. This happens when a line is moved from level to edge mode while its input is held high, or when reset is released with an input already high. In each case the pending result depends on state that cannot be seen directly at the ports. Directed sequences build these histories step by step: they hold an input high, switch its mode, or pulse reset under it, then acknowledge and watch for any fresh event. A seeded random phase follows. It mixes held and toggling inputs, random acknowledges, mode writes and occasional resets, and a bench model tracks the expected pending vector and mode value cycle by cycle.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

    // Per-line state: pending request and last sampled input level
    typedef struct packed {
        logic pend;
        logic last;
    } line_state_t;

endpackage

// File: rtl/trig_irq_ack_dec.sv
module trig_irq_ack_dec #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          ack_vld,
    input  logic [IW-1:0] ack_idx,
    output logic [N-1:0]  ack_mask
);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ack_mask[i] = ack_vld && (ack_idx == IW'(i));
        end
    end

endmodule

// File: rtl/trig_irq_mode_reg.sv
module trig_irq_mode_reg #(
    parameter int           N    = 8,
    parameter logic [N-1:0] MASK = 8'hF8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] mode_q
);

    logic [N-1:0] mode_d;

    always_comb begin
        mode_d = mode_q;
        if (rst) begin
            mode_d = '0;
        end else if (wr_en) begin
            // bits outside the writable mask are forced to edge mode
            mode_d = wr_data & MASK;
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

endmodule

// File: rtl/trig_irq_line.sv
module trig_irq_line
    import trig_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic level_mode,
    input  logic ack,
    output logic pend,
    output logic last
);

    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.last = req;
            if (level_mode) begin
                st_d.pend = req;
            end else begin
                // a fresh rise takes precedence over a same-cycle acknowledge
                st_d.pend = (req & ~st_q.last) | (st_q.pend & ~ack);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign last = st_q.last;

endmodule

// File: rtl/trig_irq_pending.sv
module trig_irq_pending #(
    parameter int               N          = 8,
    parameter logic [N-1:0]     MODE_WMASK = 8'hF8,
    localparam int              IW         = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_in,
    input  logic          ack_vld,
    input  logic [IW-1:0] ack_idx,
    input  logic          mode_wr_en,
    input  logic [N-1:0]  mode_wr_data,
    output logic [N-1:0]  pend_q,
    output logic [N-1:0]  mode_q
);

    logic [N-1:0] ack_mask;
    logic [N-1:0] last_vec;

    trig_irq_ack_dec #(.N(N), .IW(IW)) u_ack_dec (
        .ack_vld  (ack_vld),
        .ack_idx  (ack_idx),
        .ack_mask (ack_mask)
    );

    trig_irq_mode_reg #(.N(N), .MASK(MODE_WMASK)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_q  (mode_q)
    );

    for (genvar g = 0; g < N; g++) begin : g_line
        trig_irq_line u_line (
            .clk        (clk),
            .rst        (rst),
            .req        (req_in[g]),
            .level_mode (mode_q[g]),
            .ack        (ack_mask[g]),
            .pend       (pend_q[g]),
            .last       (last_vec[g])
        );
    end

endmodule

module trig_irq_checker #(
    parameter int           N    = 8,
    parameter logic [N-1:0] MASK = 8'hF8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req_in,
    input logic         mode_wr_en,
    input logic [N-1:0] mode_wr_data,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] mode_q,
    input logic [N-1:0] last_vec,
    input logic [N-1:0] ack_mask
);

    p_level_follow_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & $past(mode_q)) == ($past(req_in) & $past(mode_q))));

    p_edge_rise_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(req_in & ~last_vec & ~mode_q) & ~pend_q) == '0));

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(pend_q & ~mode_q & ~ack_mask) & ~pend_q) == '0));

    p_last_track_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (last_vec == $past(req_in)));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & $past(ack_mask & ~mode_q & ~(req_in & ~last_vec))) == '0));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(ack_mask & req_in & ~last_vec & ~mode_q) & ~pend_q) == '0));

    p_mode_write_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_wr_en)) |-> (mode_q == ($past(mode_wr_data) & MASK)));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && mode_q == '0 && last_vec == '0));

endmodule

bind trig_irq_pending trig_irq_checker #(.N(N), .MASK(MODE_WMASK)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_in       (req_in),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .pend_q       (pend_q),
    .mode_q       (mode_q),
    .last_vec     (last_vec),
    .ack_mask     (ack_mask)
);

// File: tb/test_trig_irq_pending.sv
`timescale 1ns/1ps
module test_trig_irq_pending;

    localparam logic [7:0] WMASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0;
    logic       ack_vld = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       mode_wr_en = 1'b0;
    logic [7:0] mode_wr_data = '0;
    logic [7:0] pend_q, mode_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    logic [7:0] m_pend = '0, m_last = '0, m_mode = '0;

    always #5 clk = ~clk;

    trig_irq_pending #(.N(8), .MODE_WMASK(WMASK)) i_trig_irq_pending (
        .clk(clk), .rst(rst), .req_in(req_in), .ack_vld(ack_vld), .ack_idx(ack_idx),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .pend_q(pend_q), .mode_q(mode_q)
    );

    function automatic logic [7:0] next_pend(logic [7:0] p, logic [7:0] l, logic [7:0] m,
                                             logic [7:0] r, logic av, logic [2:0] ai);
        logic [7:0] n;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) n[i] = r[i];
            else      n[i] = (r[i] & ~l[i]) | (p[i] & ~(av && ai == 3'(i)));
        end
        return n;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic r, input logic [7:0] rq, input logic av, input logic [2:0] ai,
                        input logic we, input logic [7:0] wd, input string tag);
        rst = r; req_in = rq; ack_vld = av; ack_idx = ai; mode_wr_en = we; mode_wr_data = wd;
        @(posedge clk);
        if (r) begin
            m_pend = '0; m_last = '0; m_mode = '0;
        end else begin
            m_pend = next_pend(m_pend, m_last, m_mode, rq, av, ai);
            m_last = rq;
            if (we) m_mode = wd & WMASK;
        end
        @(negedge clk);
        chk({tag, " pend"}, pend_q, m_pend);
        chk({tag, " mode"}, mode_q, m_mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R8: reset state
        step(1, 8'h00, 0, 0, 0, 8'h00, "R8 reset");
        step(1, 8'h00, 0, 0, 0, 8'h00, "R8 reset");
        chk("R8 pend literal", pend_q, 8'h00);

        // R2 edge rise, R3 hold and single event
        step(0, 8'h08, 0, 0, 0, 0, "R2 rise line3");
        chk("R2 literal", pend_q, 8'h08);
        step(0, 8'h08, 0, 0, 0, 0, "R3 held");
        step(0, 8'h08, 1, 3, 0, 0, "R5 ack edge line3");
        chk("R5 literal", pend_q, 8'h00);
        step(0, 8'h08, 0, 0, 0, 0, "R3 held after ack");
        step(0, 8'h08, 0, 0, 0, 0, "R3 held after ack");
        chk("R3 single event", pend_q, 8'h00);
        step(0, 8'h00, 0, 0, 0, 0, "R3 fall");
        step(0, 8'h08, 0, 0, 0, 0, "R2 second rise");
        step(0, 8'h00, 0, 0, 0, 0, "R3 fall keeps pending");
        chk("R3 literal", pend_q, 8'h08);
        step(0, 8'h00, 1, 3, 0, 0, "R5 ack line3");

        // R7 masked write
        step(0, 8'h00, 0, 0, 1, 8'hFF, "R7 write FF");
        chk("R7 masked literal", mode_q, 8'hF8);

        // R1 level follow; ack has no effect
        step(0, 8'h20, 0, 0, 0, 0, "R1 level high");
        step(0, 8'h20, 1, 5, 0, 0, "R1 ack level line5");
        chk("R1 ack ignored", pend_q, 8'h20);
        step(0, 8'h20, 0, 0, 0, 0, "R1 level reasserts");
        step(0, 8'h00, 0, 0, 0, 0, "R1 level low");
        chk("R1 cleared", pend_q, 8'h00);

        // R4: level line 6 held high, switched to edge
        step(0, 8'h40, 0, 0, 0, 0, "R4 level held");
        step(0, 8'h40, 0, 0, 1, 8'h00, "R4 switch to edge");
        step(0, 8'h40, 1, 6, 0, 0, "R4 ack after switch");
        step(0, 8'h40, 0, 0, 0, 0, "R4 no new event");
        chk("R4 literal", pend_q, 8'h00);
        step(0, 8'h00, 0, 0, 0, 0, "R4 release");

        // R6: rise and ack on same line same cycle
        step(0, 8'h10, 1, 4, 0, 0, "R6 set wins");
        chk("R6 literal", pend_q, 8'h10);
        step(0, 8'h00, 1, 4, 0, 0, "R5 clear line4");

        // R5 index selects one line
        step(0, 8'h06, 0, 0, 0, 0, "R5 two pending");
        step(0, 8'h00, 1, 1, 0, 0, "R5 ack line1");
        chk("R5 select literal", pend_q, 8'h04);
        step(0, 8'h00, 1, 2, 0, 0, "R5 ack line2");

        // R8: reset with input held high clears recorded level
        step(0, 8'h01, 0, 0, 1, 8'hF8, "R8 pre");
        step(1, 8'h01, 0, 0, 0, 0, "R8 mid reset");
        step(0, 8'h01, 0, 0, 0, 0, "R8 rise after reset");
        chk("R8 last cleared literal", pend_q, 8'h01);

        // seeded random phase
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] rq;
            rq = (($urandom % 4) == 0) ? 8'($urandom) : req_in;
            step(($urandom % 250) == 0, rq, ($urandom % 3) == 0, 3'($urandom),
                 ($urandom % 20) == 0, 8'($urandom), "R1/R2/R3/R5/R7 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule